// File: doc/BRIEF.md
# Two-Register Microcoded Byte Processor

This block is a very small 8-bit processor core. It has two data registers, X and T, along with a carry flag, a negative flag and a program counter. Opcodes and immediate operands come from program memory through a byte-wide read port. That port is synchronous, so data returns one clock after the address is presented.

A multi-state sequencer runs each instruction in the same order. It fetches the opcode. It then decodes it, and issues a second read when the instruction carries an operand. It executes in one cycle, except for the register exchange, which takes three. The only outputs are the halt indication and the current value of X. This is enough to run short test programs, such as a Fibonacci search that ends on the sign bit, and read the result at the end.

Top module: `xt_core`

## Requirements
- R1: While `rst_n` is low, the program counter is 0 and `pmem_addr` shows 0. X, T, carry and negative are all 0 and `halted` is 0. After release, the first opcode is fetched from address 0.
- R2: Opcode 0x01 takes two bytes (opcode, then value). It loads X with the value and sets negative to the value's bit 7.
- R3: Opcode 0x02 exchanges X and T in three XOR steps: X^=T, then T^=X, then X^=T. At the end it sets negative to bit 7 of the new X.
- R4: Opcode 0x03 clears the carry flag.
- R5: Opcode 0x04 adds X, T and carry, and writes the low 8 bits into X. The carry flag takes the carry out and the negative flag takes bit 7 of the sum.
- R6: Opcode 0x05 jumps when negative is 1, and opcode 0x06 jumps when negative is 0. Both take two bytes (opcode, then target). A taken jump loads the program counter with the target, with every bit above bit 7 forced to 0. A jump not taken continues at the byte after the target.
- R7: Opcode 0xFF raises `halted`. From then on the program counter is frozen and no read is issued, until reset.
- R8: Opcode 0x00 and any byte not listed above act as a one-byte no-op.
- R9: The program counter advances by exactly one per byte read. The carry passes cleanly between bytes, so a read of 0x00FF is followed by a read of 0x0100.
- R10: Read data is taken in the cycle after the one in which `pmem_rd` and `pmem_addr` were presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| pmem_rd | output | 1 | Program memory read strobe |
| pmem_addr | output | PC_W | Program memory byte address (the program counter) |
| pmem_rdata | input | 8 | Program memory read data, valid one cycle after the strobe |
| halted | output | 1 | High once the halt opcode has been executed |
| x_out | output | 8 | Current value of register X |

## Verification
The assertions assume that program memory returns data exactly one cycle after each strobe. They also assume that `rst_n` stays low for several clocks, so the synchronized reset reaches every register. The bench memory model always answers on the next edge. Each program is placed in a 512-byte image whose unused bytes hold the halt opcode, so a wrong branch or a skipped byte ends in a different final X rather than running away. Every scenario starts from a reset of several cycles, and outputs are sampled only on falling edges.

// File: rtl/xt_pkg.sv
package xt_pkg;

  localparam int XT_DW = 8;

  localparam logic [XT_DW-1:0] OPC_NOP = 8'h00;
  localparam logic [XT_DW-1:0] OPC_LDX = 8'h01;
  localparam logic [XT_DW-1:0] OPC_SXT = 8'h02;
  localparam logic [XT_DW-1:0] OPC_CLC = 8'h03;
  localparam logic [XT_DW-1:0] OPC_AXT = 8'h04;
  localparam logic [XT_DW-1:0] OPC_JMI = 8'h05;
  localparam logic [XT_DW-1:0] OPC_JPL = 8'h06;
  localparam logic [XT_DW-1:0] OPC_HLT = 8'hFF;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_OPND,
    ST_XCHG_B,
    ST_XCHG_C,
    ST_STOP
  } seq_state_t;

  typedef enum logic [2:0] {
    DP_IDLE,
    DP_LDX,
    DP_CLC,
    DP_ADD,
    DP_XCHG_A,
    DP_XCHG_B,
    DP_XCHG_C
  } dp_op_t;

endpackage

// File: rtl/xt_pc.sv
module xt_pc #(
  parameter int PC_W  = 16,
  parameter int TGT_W = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             load_i,
  input  logic [TGT_W-1:0] tgt_i,
  output logic [PC_W-1:0]  pc_o
);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;
  logic [PC_W-1:0] tgt_ext;
  logic            pc_en;

  generate
    if (PC_W > TGT_W) begin : g_zext
      assign tgt_ext = {{(PC_W-TGT_W){1'b0}}, tgt_i};
    end else begin : g_trunc
      assign tgt_ext = tgt_i[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    pc_en = inc_i | load_i;
    if (load_i) pc_d = tgt_ext;
    else        pc_d = pc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  AST_PC_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(rst_ni) && $past(inc_i) && !$past(load_i)) |-> (pc_q == $past(pc_q) + 1'b1)); // R9

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(inc_i) && !$past(load_i)) |-> $stable(pc_q)); // R7

endmodule

// File: rtl/xt_datapath.sv
module xt_datapath
  import xt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  dp_op_t        op_i,
  input  logic [DW-1:0] imm_i,
  output logic [DW-1:0] x_o,
  output logic          neg_o
);

  logic [DW-1:0] x_q, x_d, t_q, t_d;
  logic          c_q, c_d, n_q, n_d;
  logic          x_en, t_en, c_en, n_en;
  logic [DW:0]   sum;

  always_comb begin
    sum  = {1'b0, x_q} + {1'b0, t_q} + {{DW{1'b0}}, c_q};
    x_d  = x_q;
    t_d  = t_q;
    c_d  = c_q;
    n_d  = n_q;
    x_en = 1'b0;
    t_en = 1'b0;
    c_en = 1'b0;
    n_en = 1'b0;
    unique case (op_i)
      DP_LDX: begin
        x_d = imm_i;  x_en = 1'b1;
        n_d = imm_i[DW-1]; n_en = 1'b1;
      end
      DP_CLC: begin
        c_d = 1'b0; c_en = 1'b1;
      end
      DP_ADD: begin
        x_d = sum[DW-1:0]; x_en = 1'b1;
        c_d = sum[DW];     c_en = 1'b1;
        n_d = sum[DW-1];   n_en = 1'b1;
      end
      DP_XCHG_A: begin
        x_d = x_q ^ t_q; x_en = 1'b1;
      end
      DP_XCHG_B: begin
        t_d = t_q ^ x_q; t_en = 1'b1;
      end
      DP_XCHG_C: begin
        x_d = x_q ^ t_q; x_en = 1'b1;
        n_d = x_d[DW-1]; n_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      t_q <= '0;
      c_q <= 1'b0;
      n_q <= 1'b0;
    end else begin
      if (x_en) x_q <= x_d;
      if (t_en) t_q <= t_d;
      if (c_en) c_q <= c_d;
      if (n_en) n_q <= n_d;
    end
  end

  assign x_o   = x_q;
  assign neg_o = n_q;

  AST_LDX_VALUE: assert property (@(posedge clk) disable iff (!rst_ni)
    (op_i == DP_LDX) |=> (x_q == $past(imm_i) && n_q == $past(imm_i[DW-1]))); // R2

  AST_XCHG_RESULT: assert property (@(posedge clk) disable iff (!rst_ni)
    (op_i == DP_XCHG_C) |=> (x_q == $past(t_q, 3) && t_q == $past(x_q, 3) && n_q == x_q[DW-1])); // R3

  AST_CLC_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    (op_i == DP_CLC) |=> !c_q); // R4

  AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_ni)
    (op_i == DP_ADD) |=> ({c_q, x_q} == ({1'b0, $past(x_q)} + {1'b0, $past(t_q)} + {{DW{1'b0}}, $past(c_q)}))); // R5

endmodule

// File: rtl/xt_seq.sv
module xt_seq
  import xt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic [DW-1:0] rdata_i,
  input  logic          neg_i,
  output logic          mem_rd_o,
  output logic          pc_inc_o,
  output logic          pc_load_o,
  output logic [DW-1:0] tgt_o,
  output dp_op_t        dp_op_o,
  output logic [DW-1:0] imm_o,
  output logic          halted_o
);

  seq_state_t    state_q, state_d;
  logic [DW-1:0] ir_q;
  logic          ir_en;
  logic          known_op;

  always_comb begin
    state_d   = state_q;
    ir_en     = 1'b0;
    mem_rd_o  = 1'b0;
    pc_inc_o  = 1'b0;
    pc_load_o = 1'b0;
    dp_op_o   = DP_IDLE;
    unique case (state_q)
      ST_FETCH: begin
        mem_rd_o = 1'b1;
        pc_inc_o = 1'b1;
        state_d  = ST_DECODE;
      end
      ST_DECODE: begin
        ir_en = 1'b1;
        unique case (rdata_i)
          OPC_LDX, OPC_JMI, OPC_JPL: begin
            mem_rd_o = 1'b1;
            pc_inc_o = 1'b1;
            state_d  = ST_OPND;
          end
          OPC_SXT: begin
            dp_op_o = DP_XCHG_A;
            state_d = ST_XCHG_B;
          end
          OPC_CLC: begin
            dp_op_o = DP_CLC;
            state_d = ST_FETCH;
          end
          OPC_AXT: begin
            dp_op_o = DP_ADD;
            state_d = ST_FETCH;
          end
          OPC_HLT: state_d = ST_STOP;
          default: state_d = ST_FETCH;
        endcase
      end
      ST_OPND: begin
        unique case (ir_q)
          OPC_LDX: dp_op_o   = DP_LDX;
          OPC_JMI: pc_load_o = neg_i;
          OPC_JPL: pc_load_o = !neg_i;
          default: ;
        endcase
        state_d = ST_FETCH;
      end
      ST_XCHG_B: begin
        dp_op_o = DP_XCHG_B;
        state_d = ST_XCHG_C;
      end
      ST_XCHG_C: begin
        dp_op_o = DP_XCHG_C;
        state_d = ST_FETCH;
      end
      ST_STOP: state_d = ST_STOP;
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    ir_q <= '0;
    else if (ir_en) ir_q <= rdata_i;
  end

  assign tgt_o    = rdata_i;
  assign imm_o    = rdata_i;
  assign halted_o = (state_q == ST_STOP);
  assign known_op = (rdata_i inside {OPC_LDX, OPC_SXT, OPC_CLC, OPC_AXT, OPC_JMI, OPC_JPL, OPC_HLT});

  AST_UNKNOWN_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_DECODE && !known_op) |=> (state_q == ST_FETCH)); // R8

  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_STOP) |=> (state_q == ST_STOP)); // R7

endmodule

// File: rtl/xt_core.sv
module xt_core
  import xt_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic            pmem_rd,
  output logic [PC_W-1:0] pmem_addr,
  input  logic [7:0]      pmem_rdata,
  output logic            halted,
  output logic [7:0]      x_out
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ni = rst_sync_q[SYNC_STAGES-1];

  logic            pc_inc, pc_load, neg;
  logic [XT_DW-1:0] tgt, imm;
  dp_op_t          dp_op;

  xt_seq #(.DW(XT_DW)) u_seq (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .rdata_i  (pmem_rdata),
    .neg_i    (neg),
    .mem_rd_o (pmem_rd),
    .pc_inc_o (pc_inc),
    .pc_load_o(pc_load),
    .tgt_o    (tgt),
    .dp_op_o  (dp_op),
    .imm_o    (imm),
    .halted_o (halted)
  );

  xt_pc #(.PC_W(PC_W), .TGT_W(XT_DW)) u_pc (
    .clk    (clk),
    .rst_ni (rst_ni),
    .inc_i  (pc_inc),
    .load_i (pc_load),
    .tgt_i  (tgt),
    .pc_o   (pmem_addr)
  );

  xt_datapath #(.DW(XT_DW)) u_dp (
    .clk    (clk),
    .rst_ni (rst_ni),
    .op_i   (dp_op),
    .imm_i  (imm),
    .x_o    (x_out),
    .neg_o  (neg)
  );

  AST_JUMP_PAGE_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    pc_load |=> (pmem_rd && ((pmem_addr >> XT_DW) == '0))); // R6

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_ni)
    halted |=> (halted && !pmem_rd && $stable(pmem_addr))); // R7

  AST_RESET_ORIGIN: assert property (@(posedge clk)
    !rst_ni |-> (pmem_addr == '0 && !halted)); // R1

endmodule

// File: tb/tb_xt_core.sv
module tb_xt_core;

  localparam int CLK_PERIOD = 10;
  localparam int PC_W       = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            pmem_rd;
  logic [PC_W-1:0] pmem_addr;
  logic [7:0]      pmem_rdata;
  logic            halted;
  logic [7:0]      x_out;

  int checks = 0;
  int errors = 0;

  logic [7:0] mem [0:511];

  logic            mon_clr = 1'b1;
  logic            seen_roll, seen_low_jump, last_valid;
  logic [PC_W-1:0] last_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  xt_core #(.PC_W(PC_W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pmem_rd   (pmem_rd),
    .pmem_addr (pmem_addr),
    .pmem_rdata(pmem_rdata),
    .halted    (halted),
    .x_out     (x_out)
  );

  // synchronous program memory, one-cycle latency (R10)
  always @(posedge clk) begin
    if (pmem_rd) pmem_rdata <= mem[pmem_addr[8:0]];
  end

  always @(posedge clk) begin
    if (mon_clr) begin
      seen_roll     <= 1'b0;
      seen_low_jump <= 1'b0;
      last_valid    <= 1'b0;
      last_rd       <= '0;
    end else if (rst_n && pmem_rd) begin
      if (last_valid && last_rd == 16'h00FF && pmem_addr == 16'h0100) seen_roll <= 1'b1;
      if (seen_roll && pmem_addr == 16'h0040) seen_low_jump <= 1'b1;
      last_rd    <= pmem_addr;
      last_valid <= 1'b1;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
  endtask

  task automatic put(int a, logic [7:0] v);
    mem[a] = v;
  endtask

  task automatic do_reset();
    rst_n   = 1'b0;
    mon_clr = 1'b1;
    repeat (4) @(negedge clk);
    rst_n   = 1'b1;
    @(negedge clk);
    mon_clr = 1'b0;
  endtask

  task automatic run_to_halt(string tag);
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      if (halted) break;
      @(negedge clk);
    end
    check({tag, " halted"}, halted, 1);
  endtask

  task automatic t_reset();
    clear_mem();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset addr", pmem_addr, 0);
    check("R1 reset halted", halted, 0);
    check("R1 reset x", x_out, 0);
  endtask

  task automatic t_fib();
    clear_mem();
    put(0, 8'h00);
    put(1, 8'h01); put(2, 8'h01);
    put(3, 8'h02);
    put(4, 8'h01); put(5, 8'h00);
    put(6, 8'h03);
    put(7, 8'h04);
    put(8, 8'h05); put(9, 8'h0D);
    put(10, 8'h02);
    put(11, 8'h06); put(12, 8'h06);
    put(13, 8'hFF);
    run_to_halt("R5 fib");
    check("R5 R3 R6 fib result", x_out, 8'h90);
  endtask

  task automatic t_carry_chain();
    clear_mem();
    put(0, 8'h01); put(1, 8'hF0);
    put(2, 8'h02);
    put(3, 8'h01); put(4, 8'h20);
    put(5, 8'h04);
    put(6, 8'h04);
    put(7, 8'hFF);
    run_to_halt("R5 carry");
    check("R5 carry kept into second add", x_out, 8'h01);
  endtask

  task automatic t_clc();
    clear_mem();
    put(0, 8'h01); put(1, 8'hF0);
    put(2, 8'h02);
    put(3, 8'h01); put(4, 8'h20);
    put(5, 8'h04);
    put(6, 8'h03);
    put(7, 8'h04);
    put(8, 8'hFF);
    run_to_halt("R4 clc");
    check("R4 carry cleared before add", x_out, 8'h00);
  endtask

  task automatic t_branch();
    // add sets negative, jmi taken
    clear_mem();
    put(0, 8'h01); put(1, 8'h70);
    put(2, 8'h02);
    put(3, 8'h01); put(4, 8'h20);
    put(5, 8'h04);
    put(6, 8'h05); put(7, 8'h20);
    put(8, 8'hFF);
    put(32, 8'h01); put(33, 8'hAA); put(34, 8'hFF);
    run_to_halt("R6 taken");
    check("R6 R5 jmi taken on add sign", x_out, 8'hAA);
    // both conditions not taken
    clear_mem();
    put(0, 8'h01); put(1, 8'h05);
    put(2, 8'h05); put(3, 8'h20);
    put(4, 8'h01); put(5, 8'h85);
    put(6, 8'h06); put(7, 8'h20);
    put(8, 8'hFF);
    put(32, 8'h01); put(33, 8'hEE); put(34, 8'hFF);
    run_to_halt("R6 fallthrough");
    check("R6 R2 jumps not taken", x_out, 8'h85);
  endtask

  task automatic t_swap_flag();
    clear_mem();
    put(0, 8'h01); put(1, 8'h90);
    put(2, 8'h02);
    put(3, 8'h05); put(4, 8'h20);
    put(5, 8'h02);
    put(6, 8'h05); put(7, 8'h30);
    put(8, 8'h01); put(9, 8'hCC); put(10, 8'hFF);
    put(32, 8'h01); put(33, 8'hBB); put(34, 8'hFF);
    put(48, 8'hFF);
    run_to_halt("R3 swap");
    check("R3 swap flag and values", x_out, 8'h90);
  endtask

  task automatic t_unknown();
    clear_mem();
    put(0, 8'h00);
    put(1, 8'h01); put(2, 8'h33);
    put(3, 8'h77);
    put(4, 8'h01); put(5, 8'h44);
    put(6, 8'h10);
    put(7, 8'hFF);
    run_to_halt("R8 unknown");
    check("R8 unknown opcodes one byte", x_out, 8'h44);
  endtask

  task automatic t_rollover();
    clear_mem();
    put(0, 8'h06); put(1, 8'hF0);
    for (int a = 16'h00F0; a <= 16'h0102; a++) put(a, 8'h00);
    put(16'h0103, 8'h01); put(16'h0104, 8'h80);
    put(16'h0105, 8'h05); put(16'h0106, 8'h40);
    put(16'h0107, 8'hFF);
    put(16'h0040, 8'hFF);
    put(16'h0140, 8'h01); put(16'h0141, 8'h22); put(16'h0142, 8'hFF);
    run_to_halt("R9 rollover");
    check("R9 read 0x00FF then 0x0100", seen_roll, 1);
    check("R6 jump lands in first page", seen_low_jump, 1);
    check("R6 R2 x after page jump", x_out, 8'h80);
  endtask

  task automatic t_halt_freeze();
    logic [PC_W-1:0] a0;
    clear_mem();
    put(0, 8'h01); put(1, 8'h5A);
    put(2, 8'hFF);
    put(3, 8'h01); put(4, 8'h11);
    run_to_halt("R7 halt");
    a0 = pmem_addr;
    repeat (6) @(negedge clk);
    check("R7 address frozen", pmem_addr, a0);
    check("R7 no read when halted", pmem_rd, 0);
    check("R7 halted held", halted, 1);
    check("R7 x held", x_out, 8'h5A);
    rst_n = 1'b0;
    @(negedge clk);
    check("R7 R1 reset clears halt", halted, 0);
    check("R1 reset clears x", x_out, 0);
    check("R1 reset addr zero", pmem_addr, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_mem();
    t_reset();
    t_fib();
    t_carry_chain();
    t_clc();
    t_branch();
    t_swap_flag();
    t_unknown();
    t_rollover();
    t_halt_freeze();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule